// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a 16-bit up-counter paced by a programmable divider. The divider either splits the system clock by one of seven power-of-two ratios or counts edges of an external clock. Software programs a byte-wide control register, a 16-bit compare value and an enable input. On each pacing tick the counter steps up by one. When the counter equals the compare value at a tick, it wraps to zero, the output pin changes level and an interrupt flag is raised.

The flag stays set until software clears it or the interrupt controller sends an acknowledge. One bit of the control register selects the pin level. That bit sets the level the pin holds while the timer is stopped and also the level the pin starts from when the timer runs. A self-clearing command bit copies the live counter into a data register, so software can read a stable value. The external clock is synchronised before its edges are used.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control register reads 00h, the compare and snapshot registers read 0, `irq` is 0, and `tmr_out` is 0 while `tmr_en` is low.
- R2: Control bits [7:5] pick the pace. Codes 0 to 6 divide the system clock by 2048, 512, 64, 8, 4, 2 and 1. With divide-by-N, the counter steps on the N-th clock edge after enabling and on every N-th edge after that.
- R3: Code 7 counts the external clock. The input passes two synchroniser flops, and each selected edge gives exactly one count. Control bit 1 = 1 selects rising edges and 0 selects falling edges.
- R4: The counter runs 0,1,…,M and returns to 0 on the tick after it equals the compare value M, so one period is M+1 ticks. M is written at address 1 (low byte) and address 2 (high byte).
- R5: A tick at which the counter equals M sets the interrupt flag (control bit 4) on that edge. `irq` mirrors the flag.
- R6: The flag clears on an `irq_ack` pulse or on a control write with bit 4 = 0. A control write with bit 4 = 1 leaves it unchanged. A set in the same cycle as a clear wins.
- R7: With `tmr_en` low, `tmr_out` equals the polarity bit (control bit 2). When enabled, it starts at the inverse of that bit and toggles on every compare match.
- R8: With `tmr_en` low, the counter and the divider are held at zero, and counting restarts from zero on re-enable.
- R9: A control write with bit 0 = 1 makes bit 0 read 1 for one cycle. On the next edge the counter value is copied to the snapshot register at addresses 3 (low) and 4 (high), and the bit reads 0 again. Bit 0 written as 0 does nothing.
- R10: Control bit 3 always reads 0, whatever is written to it.
- R11: Reads from addresses 5 to 7 return 0. Writes to addresses 3 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Run enable for counter and divider |
| ext_clk | input | 1 | Asynchronous external count clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt flag |
| tmr_out | output | 1 | Timer output pin |

## Verification
The assertions check on every cycle that the divider and counter sit at zero while stopped, that the counter wraps to zero and the pin toggles after a match, and that a match sets the flag. They also check that an acknowledge without a match clears the flag, that the snapshot copies the counter one cycle after the command, and that the external source never counts on two edges in a row. Other behaviour only shows up in the bench's scenarios: the exact division ratios, the edge-polarity choice, the register read map, and the priority when a set and a clear arrive together. A reference model driven by random register traffic, acknowledges and external-clock activity covers these, together with directed runs whose values are worked out by hand.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_MLO  = 3'd1;
   localparam logic [2:0] A_MHI  = 3'd2;
   localparam logic [2:0] A_SLO  = 3'd3;
   localparam logic [2:0] A_SHI  = 3'd4;
   localparam logic [2:0] SRC_EXT = 3'b111;
   localparam int unsigned MAX_SHIFT = 11;

   // log2 of the division ratio for each internal source code
   function automatic int unsigned div_shift(input logic [2:0] code);
      case (code)
         3'd0:    return 11;
         3'd1:    return 9;
         3'd2:    return 6;
         3'd3:    return 3;
         3'd4:    return 2;
         3'd5:    return 1;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
   import ptmr_pkg::*;
#(
   parameter int PRE_W       = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] clk_sel,
   input  logic       edge_rise,
   input  logic       ext_clk,
   output logic       cnt_tick
);
   localparam int SH_W = SYNC_STAGES + 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] sel_mask;
   logic [SH_W-1:0]  sh_q;
   logic             ext_edge;

   // synchroniser chain plus one history flop, one flop per stage
   for (genvar s = 0; s < SH_W; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q[s] <= 1'b0;
         else if (s == 0) sh_q[s] <= ext_clk;
         else sh_q[s] <= sh_q[(s == 0) ? 0 : s-1];
      end
   end

   assign ext_edge = edge_rise ? ( sh_q[SH_W-2] & ~sh_q[SH_W-1])
                               : (~sh_q[SH_W-2] &  sh_q[SH_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (!run) pre_q <= '0;
      else           pre_q <= pre_q + 1'b1;
   end

   assign sel_mask = PRE_W'((64'd1 << div_shift(clk_sel)) - 64'd1);

   always_comb begin
      if (!run)                    cnt_tick = 1'b0;
      else if (clk_sel == SRC_EXT) cnt_tick = ext_edge;
      else                         cnt_tick = ((pre_q & sel_mask) == sel_mask);
   end

   AST_PRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> pre_q == '0) else $error("divider not held");                 // R8
   AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick && clk_sel == SRC_EXT) |=> !(cnt_tick && clk_sel == SRC_EXT))
      else $error("two external counts in a row");                              // R3
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] match_val,
   input  logic             idle_hi,
   output logic [CNT_W-1:0] cnt,
   output logic             match_evt,
   output logic             tmr_out
);
   logic [CNT_W-1:0] cnt_q;
   logic             phase_q;

   assign match_evt = run && tick && (cnt_q == match_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (!run) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (tick) begin
         if (cnt_q == match_val) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt     = cnt_q;
   assign tmr_out = run ? (phase_q ^ ~idle_hi) : idle_hi;

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> cnt_q == '0) else $error("no wrap after match");          // R4
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == '0) else $error("counter not held");                  // R8
   AST_OUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && run) |=> (tmr_out != $past(tmr_out)) || !run || !$stable(idle_hi))
      else $error("pin did not toggle");                                        // R7
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [2:0]       rd_addr,
   input  logic             irq_ack,
   input  logic             match_evt,
   input  logic [CNT_W-1:0] cnt,
   output logic [2:0]       clk_sel,
   output logic             pol,
   output logic             edge_rise,
   output logic [CNT_W-1:0] match_val,
   output logic             flag,
   output logic [7:0]       rd_data
);
   localparam int HI_W = CNT_W - 8;

   logic [2:0]       sel_q;
   logic             pol_q, rise_q, flag_q, pend_q;
   logic [CNT_W-1:0] match_q, snap_q;
   logic [15:0]      m16, s16;
   logic             ctrl_wr;

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         pol_q   <= 1'b0;
         rise_q  <= 1'b0;
         flag_q  <= 1'b0;
         pend_q  <= 1'b0;
         match_q <= '0;
         snap_q  <= '0;
      end else begin
         if (ctrl_wr) begin
            sel_q  <= wr_data[7:5];
            pol_q  <= wr_data[2];
            rise_q <= wr_data[1];
         end
         if (wr_en && wr_addr == A_MLO) match_q[7:0] <= wr_data;
         if (wr_en && wr_addr == A_MHI) match_q[CNT_W-1:8] <= wr_data[HI_W-1:0];
         pend_q <= ctrl_wr && wr_data[0];
         if (pend_q) snap_q <= cnt;
         if (match_evt)                               flag_q <= 1'b1;
         else if (irq_ack || (ctrl_wr && !wr_data[4])) flag_q <= 1'b0;
      end
   end

   assign m16 = 16'(match_q);
   assign s16 = 16'(snap_q);

   always_comb begin
      case (rd_addr)
         A_CTRL:  rd_data = {sel_q, flag_q, 1'b0, pol_q, rise_q, pend_q};
         A_MLO:   rd_data = m16[7:0];
         A_MHI:   rd_data = m16[15:8];
         A_SLO:   rd_data = s16[7:0];
         A_SHI:   rd_data = s16[15:8];
         default: rd_data = 8'h00;
      endcase
   end

   assign clk_sel   = sel_q;
   assign pol       = pol_q;
   assign edge_rise = rise_q;
   assign match_val = match_q;
   assign flag      = flag_q;

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> flag_q) else $error("flag not set");                      // R5
   AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !match_evt) |=> !flag_q) else $error("ack did not clear");  // R6
   AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> snap_q == $past(cnt)) else $error("snapshot wrong");         // R9
   AST_SNAP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !(ctrl_wr && wr_data[0])) |=> !pend_q)
      else $error("command bit stuck");                                        // R9
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tmr_en,
   input  logic       ext_clk,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [2:0] rd_addr,
   output logic [7:0] rd_data,
   input  logic       irq_ack,
   output logic       irq,
   output logic       tmr_out
);
   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 9..16");
   end
   if (PRE_W < int'(MAX_SHIFT)) begin : g_bad_pre
      $error("PRE_W too small for the largest ratio");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchroniser stages required");
   end

   logic [2:0]       clk_sel;
   logic             pol, edge_rise, tick, match_evt;
   logic [CNT_W-1:0] match_val, cnt;

   ptmr_regs #(.CNT_W(CNT_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .irq_ack(irq_ack),
      .match_evt(match_evt), .cnt(cnt), .clk_sel(clk_sel), .pol(pol),
      .edge_rise(edge_rise), .match_val(match_val), .flag(irq),
      .rd_data(rd_data)
   );

   ptmr_prescaler #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) pre_i (
      .clk(clk), .rst_n(rst_n), .run(tmr_en), .clk_sel(clk_sel),
      .edge_rise(edge_rise), .ext_clk(ext_clk), .cnt_tick(tick)
   );

   ptmr_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .run(tmr_en), .tick(tick),
      .match_val(match_val), .idle_hi(pol), .cnt(cnt),
      .match_evt(match_evt), .tmr_out(tmr_out)
   );
endmodule

// File: tb/ptmr_top_tb_top.sv
`timescale 1ns/100ps
module ptmr_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tmr_en = 1'b0, ext_clk = 1'b0, wr_en = 1'b0, irq_ack = 1'b0;
   logic [2:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       irq, tmr_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ptmr_top dut_i (
      .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .ext_clk(ext_clk),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_ack(irq_ack),
      .irq(irq), .tmr_out(tmr_out)
   );

   // reference model built from the requirements
   logic [10:0] m_pre;
   logic [15:0] m_cnt, m_match, m_snap;
   logic [2:0]  m_ck;
   logic        m_pol, m_ece, m_flag, m_pend, m_ph, m_s1, m_s2, m_s3;

   function automatic logic [10:0] ratio_mask(input logic [2:0] c);
      case (c)
         3'd0: return 11'h7FF;  3'd1: return 11'h1FF;
         3'd2: return 11'h03F;  3'd3: return 11'h007;
         3'd4: return 11'h003;  3'd5: return 11'h001;
         default: return 11'h000;
      endcase
   endfunction

   function automatic logic m_tick_f();
      if (!tmr_en) return 1'b0;
      if (m_ck == 3'd7) return m_ece ? (m_s2 & ~m_s3) : (~m_s2 & m_s3);
      return (m_pre & ratio_mask(m_ck)) == ratio_mask(m_ck);
   endfunction

   function automatic logic [7:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0: return {m_ck, m_flag, 1'b0, m_pol, m_ece, m_pend};
         3'd1: return m_match[7:0];
         3'd2: return m_match[15:8];
         3'd3: return m_snap[7:0];
         3'd4: return m_snap[15:8];
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic exp_out();
      return tmr_en ? (m_ph ^ ~m_pol) : m_pol;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pre <= '0; m_cnt <= '0; m_match <= '0; m_snap <= '0; m_ck <= '0;
         m_pol <= 0; m_ece <= 0; m_flag <= 0; m_pend <= 0; m_ph <= 0;
         m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
      end else begin
         logic tk, ev, cw;
         tk = m_tick_f();
         ev = tk && (m_cnt == m_match);
         cw = wr_en && wr_addr == 3'd0;
         m_s1 <= ext_clk; m_s2 <= m_s1; m_s3 <= m_s2;
         m_pre <= tmr_en ? m_pre + 11'd1 : 11'd0;
         if (!tmr_en) begin m_cnt <= 0; m_ph <= 0; end
         else if (ev) begin m_cnt <= 0; m_ph <= ~m_ph; end
         else if (tk) m_cnt <= m_cnt + 16'd1;
         if (ev) m_flag <= 1;
         else if (irq_ack || (cw && !wr_data[4])) m_flag <= 0;
         if (cw) begin m_ck <= wr_data[7:5]; m_pol <= wr_data[2]; m_ece <= wr_data[1]; end
         if (wr_en && wr_addr == 3'd1) m_match[7:0]  <= wr_data;
         if (wr_en && wr_addr == 3'd2) m_match[15:8] <= wr_data;
         m_pend <= cw && wr_data[0];
         if (m_pend) m_snap <= m_cnt;
      end
   end

   task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string req);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
      end
   endtask

   // one clock edge, then compare pins and the read port against the model
   task automatic cyc();
      @(posedge clk); #1;
      chk(16'(tmr_out), 16'(exp_out()), "R7");
      chk(16'(irq), 16'(m_flag), "R5");
      chk(16'(rd_data), 16'(exp_rd(rd_addr)), "R11");
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [7:0] expv, input string req);
      rd_addr = a; #1;
      chk(16'(rd_data), 16'(expv), req);
   endtask

   task automatic ext_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         ext_clk = 1; cycles(3);
         ext_clk = 0; cycles(3);
      end
   endtask

   initial begin
      #(5.0 * 190000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1bad5eed));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset values
      rd_chk(3'd0, 8'h00, "R1");
      chk(16'(tmr_out), 16'h0, "R1");
      chk(16'(irq), 16'h0, "R1");
      rd_chk(3'd1, 8'h00, "R1");
      // R10 reserved bit, R7 idle level follows polarity
      wr(3'd0, 8'h0C);
      rd_chk(3'd0, 8'h04, "R10");
      chk(16'(tmr_out), 16'h1, "R7");
      // R2 divide by 2048: three steps after 3*2048 edges
      wr(3'd0, 8'h00); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
      tmr_en = 1;
      cycles(3 * 2048);
      wr(3'd0, 8'h01);
      rd_chk(3'd0, 8'h01, "R9");
      cyc();
      rd_chk(3'd0, 8'h00, "R9");
      rd_chk(3'd3, 8'h03, "R2");
      rd_chk(3'd4, 8'h00, "R2");
      // R8 disable holds at zero
      tmr_en = 0; cyc();
      wr(3'd0, 8'h01); cyc();
      rd_chk(3'd3, 8'h00, "R8");
      // R3 rising edges
      wr(3'd0, 8'hE2); tmr_en = 1; cyc();
      ext_pulses(5);
      wr(3'd0, 8'hE3); cyc();
      rd_chk(3'd3, 8'h05, "R3");
      // R3 falling edges
      tmr_en = 0; cyc();
      wr(3'd0, 8'hE0); tmr_en = 1; cyc();
      ext_pulses(4);
      wr(3'd0, 8'hE1); cyc();
      rd_chk(3'd3, 8'h04, "R3");
      // R4/R5/R7 divide by 1, compare 4
      tmr_en = 0; cyc();
      wr(3'd1, 8'h04); wr(3'd2, 8'h00); wr(3'd0, 8'hC0);
      tmr_en = 1;
      cycles(4);
      chk(16'(tmr_out), 16'h1, "R7");
      chk(16'(irq), 16'h0, "R4");
      cyc();
      chk(16'(tmr_out), 16'h0, "R7");
      chk(16'(irq), 16'h1, "R5");
      // R6 write 1 keeps flag, write 0 clears
      tmr_en = 0; cyc();
      wr(3'd0, 8'hD0);
      chk(16'(irq), 16'h1, "R6");
      wr(3'd0, 8'hC0);
      chk(16'(irq), 16'h0, "R6");
      // R6 set wins over acknowledge (compare 0: event every tick)
      wr(3'd1, 8'h00);
      tmr_en = 1; irq_ack = 1;
      cycles(3);
      chk(16'(irq), 16'h1, "R6");
      tmr_en = 0; cyc(); irq_ack = 0;
      chk(16'(irq), 16'h0, "R6");
      // R11 unmapped reads and ignored writes
      wr(3'd3, 8'h55); wr(3'd4, 8'hAA); wr(3'd6, 8'h77);
      rd_chk(3'd3, 8'h04, "R11");
      rd_chk(3'd4, 8'h00, "R11");
      rd_chk(3'd5, 8'h00, "R11");
      rd_chk(3'd7, 8'h00, "R11");
      // constrained random traffic against the model
      for (int t = 0; t < 30; t++) begin
         logic [2:0] code;
         logic       p, e;
         code = 3'($urandom_range(2, 7));
         p = 1'($urandom_range(0, 1));
         e = 1'($urandom_range(0, 1));
         tmr_en = 0; cyc();
         wr(3'd1, 8'($urandom_range(0, 12)));
         wr(3'd2, 8'h00);
         wr(3'd0, {code, 2'b00, p, e, 1'b0});
         tmr_en = 1;
         for (int c = 0; c < 300; c++) begin
            rd_addr = 3'($urandom_range(0, 7));
            irq_ack = ($urandom_range(0, 11) == 0);
            if ($urandom_range(0, 3) == 0) ext_clk = ~ext_clk;
            if ($urandom_range(0, 59) == 0) tmr_en = ~tmr_en;
            if ($urandom_range(0, 9) == 0) begin
               wr_en = 1; wr_addr = 3'd0;
               wr_data = {code, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                          p, e, 1'($urandom_range(0, 1))};
            end
            cyc();
            wr_en = 0; irq_ack = 0;
         end
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule